// File: doc/BRIEF.md
# Time-of-Day Counter Low Word with Capture Latch

This block is the fast, low-order part of a time-of-day clock. A free-running counter advances once for every pulse of a prescaled count enable. Software keeps the high-order part of the time in memory. Each time the counter wraps, the block raises a sticky tick interrupt, and software uses that interrupt to bump the high-order part.

To read the time without tearing, software pulses a read strobe. The strobe copies the counter into a holding register, where it can be read at leisure. An external pulse-per-second input can also load the holding register directly. Such a capture records the moment of the second edge without any interrupt latency.

A pulse-per-second capture outranks a software read strobe. Once it has been taken, it stays held until software consumes it, and read strobes that arrive meanwhile are refused and reported. The held value leaves the block on a valid/ready pair:
- `snap_valid` says that an unconsumed sample is present, and `snap_ready` consumes it.
- Captures never wait for `snap_ready`. A new capture may replace a held software sample at any time, and a new second edge always replaces the held value.
- While `snap_valid` is low, `snap_ready` has no effect.

Top module: `tod_capture_counter`

## Requirements
- R1: After reset the counter is 0 and snap_data, snap_valid, snap_is_pps, rd_dropped and tick_irq are all 0.
- R2: The counter increments by one on each clock edge that sees cnt_en high, holds otherwise, and wraps from 16'hFFFF to 16'h0000 without saturating.
- R3: A read strobe that is accepted copies the counter value present before that edge into snap_data. From the next cycle snap_valid is 1 and snap_is_pps is 0.
- R4: pps_in passes through a two-flop synchronizer and is edge-detected. The counter is captured on the third rising clock edge that sees pps_in high. From then on snap_valid and snap_is_pps are 1. Each low-to-high transition makes exactly one capture, and a level held high makes no further captures.
- R5: A read strobe is refused in two cases: on the edge where a pulse-per-second capture occurs, and while an unconsumed pulse-per-second sample is held. A refused strobe leaves snap_data and snap_is_pps unchanged.
- R6: rd_dropped goes to 1 the cycle after a refused read strobe and stays 1 until a handshake (snap_valid and snap_ready at one edge) that has no refused strobe at the same edge.
- R7: A handshake clears snap_valid in the next cycle unless a capture occurs at the same edge, in which case the new sample is valid. snap_ready with snap_valid low has no effect.
- R8: A read strobe while an unconsumed software sample is held is accepted and overwrites it.
- R9: A counter wrap sets tick_irq in the next cycle, and tick_irq stays 1 until acknowledged.
- R10: tick_ack clears tick_irq in the next cycle, except when a wrap occurs at the same edge, in which case tick_irq is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_en | input | 1 | Prescaler output pulse, advances the counter |
| rd_strobe | input | 1 | Software request to latch the counter |
| pps_in | input | 1 | Asynchronous pulse-per-second input |
| tick_ack | input | 1 | Software acknowledge of the tick interrupt |
| snap_ready | input | 1 | Consumes the held sample |
| snap_data | output | 16 | Held counter sample |
| snap_valid | output | 1 | An unconsumed sample is held |
| snap_is_pps | output | 1 | Held sample came from pulse-per-second |
| rd_dropped | output | 1 | A read strobe was refused since the last handshake |
| tick_irq | output | 1 | Sticky counter-overflow interrupt |

## Verification
Several results take one cycle: a read-strobe capture, the counter step, a handshake, the tick set and clear, and the drop flag all appear one cycle after the edge that sees their inputs. A pulse-per-second capture appears three edges after pps_in first goes high. The bench drives inputs between edges and updates its reference model at each rising edge. It compares every output one time unit after that edge, so each result is checked in the cycle it becomes due. The synchronizer delay is modelled as an explicit three-stage history of pps_in.

// File: rtl/tod_pkg.sv
package tod_pkg;
  typedef enum logic {
    SRC_SOFT = 1'b0,
    SRC_PPS  = 1'b1
  } snap_src_e;
endpackage

// File: rtl/tod_pps_edge.sv
module tod_pps_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pps_in,
  output logic pps_rise
);
  localparam int DEPTH = STAGES + 1;
  logic [DEPTH-1:0] hist_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rst_n) hist_q[g] <= 1'b0;
        else        hist_q[g] <= pps_in;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rst_n) hist_q[g] <= 1'b0;
        else        hist_q[g] <= hist_q[g-1];
      end
    end
  end

  assign pps_rise = hist_q[STAGES-1] & ~hist_q[STAGES];
endmodule

// File: rtl/tod_low_counter.sv
module tod_low_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cnt_en,
  output logic [W-1:0] count,
  output logic         wrap
);
  localparam logic [W-1:0] TOP = {W{1'b1}};
  logic [W-1:0] count_q;

  assign wrap = cnt_en && (count_q == TOP);

  always_ff @(posedge clk) begin
    if (!rst_n)      count_q <= '0;
    else if (cnt_en) count_q <= count_q + 1'b1;
  end

  assign count = count_q;
endmodule

// File: rtl/tod_tick_latch.sv
module tod_tick_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic wrap,
  input  logic ack,
  output logic irq
);
  logic irq_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    irq_q <= 1'b0;
    else if (wrap) irq_q <= 1'b1;
    else if (ack)  irq_q <= 1'b0;
  end

  assign irq = irq_q;
endmodule

// File: rtl/tod_snapshot.sv
module tod_snapshot
  import tod_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] count,
  input  logic         pps_rise,
  input  logic         rd_strobe,
  input  logic         ready,
  output logic [W-1:0] data,
  output logic         valid,
  output logic         is_pps,
  output logic         dropped
);
  logic [W-1:0] data_q;
  logic         valid_q;
  snap_src_e    src_q;
  logic         dropped_q;
  logic         pps_held, take_soft, refuse, pop;

  assign pps_held  = valid_q && (src_q == SRC_PPS);
  assign take_soft = rd_strobe && !pps_rise && !pps_held;
  assign refuse    = rd_strobe && (pps_rise || pps_held);
  assign pop       = valid_q && ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q  <= '0;
      valid_q <= 1'b0;
      src_q   <= SRC_SOFT;
    end else if (pps_rise) begin
      data_q  <= count;
      valid_q <= 1'b1;
      src_q   <= SRC_PPS;
    end else if (take_soft) begin
      data_q  <= count;
      valid_q <= 1'b1;
      src_q   <= SRC_SOFT;
    end else if (pop) begin
      valid_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      dropped_q <= 1'b0;
    else if (refuse) dropped_q <= 1'b1;
    else if (pop)    dropped_q <= 1'b0;
  end

  assign data    = data_q;
  assign valid   = valid_q;
  assign is_pps  = (src_q == SRC_PPS);
  assign dropped = dropped_q;
endmodule

// File: rtl/tod_capture_counter.sv
module tod_capture_counter #(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  input  logic             rd_strobe,
  input  logic             pps_in,
  input  logic             tick_ack,
  input  logic             snap_ready,
  output logic [CNT_W-1:0] snap_data,
  output logic             snap_valid,
  output logic             snap_is_pps,
  output logic             rd_dropped,
  output logic             tick_irq
);
  logic [CNT_W-1:0] count_q;
  logic             wrap_pulse;
  logic             pps_rise;

  tod_pps_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst_n(rst_n), .pps_in(pps_in), .pps_rise(pps_rise)
  );

  tod_low_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .count(count_q), .wrap(wrap_pulse)
  );

  tod_tick_latch u_tick (
    .clk(clk), .rst_n(rst_n), .wrap(wrap_pulse), .ack(tick_ack), .irq(tick_irq)
  );

  tod_snapshot #(.W(CNT_W)) u_snap (
    .clk(clk), .rst_n(rst_n), .count(count_q), .pps_rise(pps_rise),
    .rd_strobe(rd_strobe), .ready(snap_ready), .data(snap_data),
    .valid(snap_valid), .is_pps(snap_is_pps), .dropped(rd_dropped)
  );
endmodule

// File: rtl/tod_capture_checker.sv
module tod_capture_checker #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cnt_en,
  input logic         rd_strobe,
  input logic         tick_ack,
  input logic         snap_ready,
  input logic [W-1:0] snap_data,
  input logic         snap_valid,
  input logic         snap_is_pps,
  input logic         rd_dropped,
  input logic         tick_irq,
  input logic [W-1:0] count,
  input logic         wrap,
  input logic         pps_rise
);
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_en |=> count == W'($past(count) + 1'b1)); // R2
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_en |=> $stable(count)); // R2
  AST_RD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && !pps_rise && !(snap_valid && snap_is_pps))
    |=> (snap_valid && !snap_is_pps && snap_data == $past(count))); // R3
  AST_PPS_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    pps_rise |=> (snap_valid && snap_is_pps && snap_data == $past(count))); // R4
  AST_PPS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (snap_valid && snap_is_pps && !snap_ready && !pps_rise)
    |=> (snap_valid && snap_is_pps && $stable(snap_data))); // R5
  AST_DROP_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && (pps_rise || (snap_valid && snap_is_pps))) |=> rd_dropped); // R6
  AST_HS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (snap_valid && snap_ready && !rd_strobe && !pps_rise) |=> !snap_valid); // R7
  AST_WRAP_SET: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> tick_irq); // R9
  AST_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_irq && !tick_ack) |=> tick_irq); // R9
  AST_TICK_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_ack && !wrap) |=> !tick_irq); // R10
endmodule

bind tod_capture_counter tod_capture_checker #(.W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .rd_strobe(rd_strobe),
  .tick_ack(tick_ack), .snap_ready(snap_ready), .snap_data(snap_data),
  .snap_valid(snap_valid), .snap_is_pps(snap_is_pps), .rd_dropped(rd_dropped),
  .tick_irq(tick_irq), .count(count_q), .wrap(wrap_pulse), .pps_rise(pps_rise)
);

// File: tb/test_tod_capture_counter.sv
module test_tod_capture_counter;
  localparam int CLK_PERIOD = 10;
  localparam int LIMIT      = 190000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cnt_en = 1'b0, rd_strobe = 1'b0, pps_in = 1'b0;
  logic        tick_ack = 1'b0, snap_ready = 1'b0;
  logic [15:0] snap_data;
  logic        snap_valid, snap_is_pps, rd_dropped, tick_irq;

  int    n_checks = 0;
  int    n_fail   = 0;
  int    n_cycles = 0;
  bit    done     = 1'b0;
  string tag      = "R1";

  logic [15:0] m_cnt = '0, m_data = '0;
  logic        m_valid = 0, m_pps = 0, m_drop = 0, m_tick = 0;
  logic [2:0]  m_hist = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tod_capture_counter i_tod_capture_counter (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .rd_strobe(rd_strobe),
    .pps_in(pps_in), .tick_ack(tick_ack), .snap_ready(snap_ready),
    .snap_data(snap_data), .snap_valid(snap_valid), .snap_is_pps(snap_is_pps),
    .rd_dropped(rd_dropped), .tick_irq(tick_irq)
  );

  function automatic bit next_tick(input bit cur, input bit wrp, input bit ack);
    if (wrp) return 1'b1;
    if (ack) return 1'b0;
    return cur;
  endfunction

  task automatic check(input string what, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all();
    check("snap_data", snap_data, m_data);
    check("snap_valid", 16'(snap_valid), 16'(m_valid));
    check("snap_is_pps", 16'(snap_is_pps), 16'(m_pps));
    check("rd_dropped", 16'(rd_dropped), 16'(m_drop));
    check("tick_irq", 16'(tick_irq), 16'(m_tick));
  endtask

  task automatic cycle(input bit en, input bit rd, input bit pps, input bit rdy, input bit ack);
    bit rise, held, pop, wrp;
    cnt_en = en; rd_strobe = rd; pps_in = pps; snap_ready = rdy; tick_ack = ack;
    @(posedge clk);
    n_cycles++;
    rise = m_hist[1] & ~m_hist[2];
    held = m_valid & m_pps;
    pop  = m_valid & rdy;
    wrp  = en && (m_cnt == 16'hFFFF);
    if (rise) begin
      m_data = m_cnt; m_pps = 1; m_valid = 1;
    end else if (rd && !held) begin
      m_data = m_cnt; m_pps = 0; m_valid = 1;
    end else if (pop) begin
      m_valid = 0;
    end
    if (rd && (rise || held)) m_drop = 1;
    else if (pop)             m_drop = 0;
    m_tick = next_tick(m_tick, wrp, ack);
    m_hist = {m_hist[1:0], pps};
    m_cnt  = m_cnt + 16'(en);
    #1;
    compare_all();
  endtask

  initial begin
    while (!done && n_cycles < LIMIT) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", n_cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    bit pps_lvl;
    int seed;
    seed = 32'h5eed_1234;
    void'($urandom(seed));
    repeat (3) @(posedge clk);
    #1;
    tag = "R1"; compare_all();
    rst_n = 1'b1;
    // R1 counter starts at zero: immediate read
    tag = "R1"; cycle(0, 1, 0, 0, 0);
    // R2 stepping and holding, R3 read value
    tag = "R2"; repeat (5) cycle(1, 0, 0, 0, 0);
    cycle(0, 0, 0, 0, 0);
    tag = "R3"; cycle(1, 1, 0, 0, 0);
    // R8 overwrite of unread software sample
    tag = "R8"; cycle(1, 0, 0, 0, 0); cycle(0, 1, 0, 0, 0);
    // R7 handshake then ready with nothing held
    tag = "R7"; cycle(0, 0, 0, 1, 0); cycle(1, 0, 0, 1, 0);
    // R4 pps capture at third edge, held level gives no second capture
    tag = "R4"; cycle(1, 0, 1, 0, 0); cycle(1, 0, 1, 0, 0); cycle(1, 0, 1, 0, 0);
    repeat (4) cycle(1, 0, 1, 0, 0);
    // R5 strobe refused while pps sample held
    tag = "R5"; cycle(1, 1, 1, 0, 0); cycle(1, 0, 0, 0, 0);
    // R6 drop flag persists, cleared by handshake
    tag = "R6"; repeat (2) cycle(1, 0, 0, 0, 0); cycle(1, 0, 0, 1, 0); cycle(1, 0, 0, 0, 0);
    // R5 strobe on same edge as pps capture
    tag = "R5"; cycle(1, 0, 1, 0, 0); cycle(1, 0, 1, 0, 0); cycle(1, 1, 1, 0, 0);
    cycle(1, 0, 0, 0, 0);
    // R7 handshake at a capture edge keeps new sample valid
    tag = "R7"; cycle(1, 0, 1, 0, 0); cycle(1, 0, 1, 0, 0); cycle(1, 0, 0, 1, 0);
    cycle(1, 0, 0, 1, 0); cycle(1, 0, 0, 0, 0);
    // R2/R9 wrap sets tick, held until ack
    tag = "R9";
    while (m_cnt != 16'hFFFF) cycle(1, 0, 0, 0, 0);
    cycle(1, 1, 0, 0, 0);
    repeat (3) cycle(0, 0, 0, 0, 0);
    // R10 ack clears
    tag = "R10"; cycle(0, 0, 0, 0, 1); cycle(0, 0, 0, 0, 0);
    // R10 wrap and ack at the same edge keeps tick set
    tag = "R2";
    while (m_cnt != 16'hFFFF) cycle(1, 0, 0, 0, 0);
    tag = "R10"; cycle(1, 0, 0, 0, 1); cycle(0, 0, 0, 0, 0);
    cycle(1, 1, 0, 1, 0);
    // constrained random mix
    tag = "R2";
    pps_lvl = 0;
    for (int i = 0; i < 3000; i++) begin
      if (($urandom % 40) == 0) pps_lvl = ~pps_lvl;
      cycle(($urandom % 4) != 0, ($urandom % 10) == 0, pps_lvl,
            ($urandom % 7) == 0, ($urandom % 10) == 0);
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule